// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block is the front-end control of a scalar five-stage 32-bit RISC pipeline. It owns the program counter and the register between fetch and decode. It evaluates branch conditions and targets while the branch is in decode, and it chooses the next fetch address. Instruction memory answers combinationally: the word at `fetch_pc` arrives on `fetch_instr` in the same cycle. An external decoder classifies the word held in the fetch-to-decode register and supplies its branch kind, its likely flag, its register operands, its sign-extended offset and its jump index.

The default mode exposes one architectural delay slot. The word fetched while a branch sits in decode is executed on both outcomes, unless the branch is a likely branch that is not taken; in that case the slot is annulled to a nop. With `ZAP_MODE` set there is no exposed slot. Each branch in decode replaces the word just fetched with a nop and lets the branch continue. A hazard stall freezes the front end. A delay-slot word caught under a stall stays intact in decode, and only words fetched after it are discarded.

The sequencer has three named states. RUN means an ordinary word (or nothing) is in decode. SLOT means a delay-slot word is in decode. BUBBLE means an annulled or zapped nop is in decode. A RUN cycle with a valid branch and no stall moves to SLOT in delayed mode. It moves to BUBBLE instead for a not-taken likely branch, and for every branch in zap mode. SLOT and BUBBLE return to RUN on the next cycle without a stall. All states hold while the stall input is high.

Top module: `delay_fetch_seq`

## Requirements
- R1: A synchronous reset sets `fetch_pc` to `RESET_VEC`, `ifid_instr` to zero and `ifid_valid` to 0.
- R2: With no redirect, no hold and no stall, each clock edge advances `fetch_pc` by 4 and loads `fetch_instr` into `ifid_instr` with `ifid_valid` = 1.
- R3: The `dec_kind` codes are 0 none, 1 equal, 2 not-equal, 3 rs<=0, 4 rs>0, 5 rs<0, 6 rs>=0 and 7 jump (always taken). Comparisons are signed 32-bit, and kinds 1 and 2 compare rs with rt.
- R4: For a taken branch, `branch_taken` is high in the decode cycle, and the next `fetch_pc` is the delay-slot address (the current `fetch_pc`) plus `off_ext` shifted left by two. In delayed mode the delay-slot word enters decode with `ifid_valid` = 1.
- R5: The jump target is the upper 4 bits of the delay-slot address, followed by `jump_idx`, followed by two zero bits.
- R6: In delayed mode a not-taken ordinary branch keeps its delay slot valid, and fetch continues at slot address + 4.
- R7: For a likely branch (`dec_likely` = 1), a taken outcome keeps the slot. A not-taken outcome loads the nop (all-zero word) with `ifid_valid` = 0, and fetch continues sequentially.
- R8: While `stall_req` is high, `fetch_pc`, `ifid_instr` and `ifid_valid` hold and `branch_taken` stays low. A branch in decode is then acted on in the first cycle after the stall ends.
- R9: A delay-slot word that is stalled in decode keeps its word and valid bit through the whole stall.
- R10: A branch in a delay slot raises `slot_error`, is not acted on, and fetch continues sequentially.
- R11: With `ZAP_MODE` = 1, a branch in decode loads a nop with `ifid_valid` = 0. The PC holds when the branch is not taken and goes to the target when it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_instr | input | 32 | Word read at `fetch_pc` |
| dec_kind | input | 3 | Branch kind of the word in decode |
| dec_likely | input | 1 | Word in decode is a likely branch |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| off_ext | input | 32 | Sign-extended branch offset, in words |
| jump_idx | input | 26 | Jump index field |
| stall_req | input | 1 | Hazard stall request |
| fetch_pc | output | 32 | Fetch address |
| ifid_instr | output | 32 | Word held for decode |
| ifid_valid | output | 1 | Decode word is valid |
| branch_taken | output | 1 | Redirect taken this cycle |
| slot_error | output | 1 | Branch found in a delay slot |

## Verification
The assertions assume that `dec_kind`, `dec_likely` and the operand inputs describe the word currently in `ifid_instr`, and that they stay settled while `stall_req` is high. They also assume that reset is held for at least one edge before any property counts. The bench sets every input once per cycle, well after the clock edge. It only gives branch kinds for decode words that actually hold a branch, and it places a branch in a delay slot only in the case that is meant to raise `slot_error`.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    localparam int unsigned KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        BK_NONE = 3'd0,
        BK_EQ   = 3'd1,
        BK_NE   = 3'd2,
        BK_LEZ  = 3'd3,
        BK_GTZ  = 3'd4,
        BK_LTZ  = 3'd5,
        BK_GEZ  = 3'd6,
        BK_JUMP = 3'd7
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLOT   = 2'd1,
        ST_BUBBLE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dfs_cond.sv
module dfs_cond
    import dfs_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  br_kind_e          kind,
    input  logic [WORD_W-1:0] rs_val,
    input  logic [WORD_W-1:0] rt_val,
    output logic              take
);
    logic signed [WORD_W-1:0] rs_s;
    assign rs_s = $signed(rs_val);

    always_comb begin
        unique case (kind)
            BK_NONE: take = 1'b0;
            BK_EQ:   take = (rs_val == rt_val);
            BK_NE:   take = (rs_val != rt_val);
            BK_LEZ:  take = (rs_s <= 0);
            BK_GTZ:  take = (rs_s > 0);
            BK_LTZ:  take = (rs_s < 0);
            BK_GEZ:  take = (rs_s >= 0);
            BK_JUMP: take = 1'b1;
        endcase
    end
endmodule

// File: rtl/dfs_target.sv
module dfs_target #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              is_jump,
    input  logic [WORD_W-1:0] slot_pc,
    input  logic [WORD_W-1:0] off_ext,
    input  logic [WORD_W-7:0] jump_idx,
    output logic [WORD_W-1:0] target
);
    localparam int unsigned REGION_W = 4;

    logic [WORD_W-1:0] br_tgt;
    logic [WORD_W-1:0] jmp_tgt;

    assign br_tgt  = slot_pc + (off_ext << 2);
    assign jmp_tgt = {slot_pc[WORD_W-1 -: REGION_W], jump_idx, 2'b00};
    assign target  = is_jump ? jmp_tgt : br_tgt;
endmodule

// File: rtl/dfs_fsm.sv
module dfs_fsm
    import dfs_pkg::*;
#(
    parameter bit ZAP_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic stall,
    input  logic dec_valid,
    input  logic is_branch,
    input  logic take,
    input  logic likely,
    output logic redirect,
    output logic nop_fill,
    output logic pc_hold,
    output logic slot_err
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        redirect = 1'b0;
        nop_fill = 1'b0;
        pc_hold  = 1'b0;
        slot_err = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (dec_valid && is_branch && !stall) begin
                    redirect = take;
                    if (ZAP_MODE) begin
                        nop_fill = 1'b1;
                        pc_hold  = !take;
                        state_d  = ST_BUBBLE;
                    end else if (likely && !take) begin
                        nop_fill = 1'b1;
                        state_d  = ST_BUBBLE;
                    end else begin
                        state_d  = ST_SLOT;
                    end
                end
            end
            ST_SLOT: begin
                slot_err = dec_valid && is_branch;
                if (!stall) state_d = ST_RUN;
            end
            ST_BUBBLE: begin
                if (!stall) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end
endmodule

// File: rtl/delay_fetch_seq.sv
module delay_fetch_seq
    import dfs_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter logic [31:0] RESET_VEC = 32'h0000_0000,
    parameter bit          ZAP_MODE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] fetch_instr,
    input  logic [2:0]        dec_kind,
    input  logic              dec_likely,
    input  logic [WORD_W-1:0] rs_val,
    input  logic [WORD_W-1:0] rt_val,
    input  logic [WORD_W-1:0] off_ext,
    input  logic [WORD_W-7:0] jump_idx,
    input  logic              stall_req,
    output logic [WORD_W-1:0] fetch_pc,
    output logic [WORD_W-1:0] ifid_instr,
    output logic              ifid_valid,
    output logic              branch_taken,
    output logic              slot_error
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(4);
    localparam logic [WORD_W-1:0] NOP  = '0;

    br_kind_e          kind;
    logic              take;
    logic [WORD_W-1:0] tgt;
    logic              redirect, nop_fill, pc_hold;
    logic [WORD_W-1:0] pc_q, instr_q;
    logic              valid_q;

    assign kind = br_kind_e'(dec_kind);

    dfs_cond #(.WORD_W(WORD_W)) u_cond (
        .kind   (kind),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .take   (take)
    );

    dfs_target #(.WORD_W(WORD_W)) u_target (
        .is_jump  (kind == BK_JUMP),
        .slot_pc  (pc_q),
        .off_ext  (off_ext),
        .jump_idx (jump_idx),
        .target   (tgt)
    );

    dfs_fsm #(.ZAP_MODE(ZAP_MODE)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall_req),
        .dec_valid (valid_q),
        .is_branch (kind != BK_NONE),
        .take      (take),
        .likely    (dec_likely),
        .redirect  (redirect),
        .nop_fill  (nop_fill),
        .pc_hold   (pc_hold),
        .slot_err  (slot_error)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= WORD_W'(RESET_VEC);
            instr_q <= NOP;
            valid_q <= 1'b0;
        end else if (!stall_req) begin
            if (redirect)     pc_q <= tgt;
            else if (!pc_hold) pc_q <= pc_q + STEP;
            if (nop_fill) begin
                instr_q <= NOP;
                valid_q <= 1'b0;
            end else begin
                instr_q <= fetch_instr;
                valid_q <= 1'b1;
            end
        end
    end

    assign fetch_pc     = pc_q;
    assign ifid_instr   = instr_q;
    assign ifid_valid   = valid_q;
    assign branch_taken = redirect;
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
    parameter int unsigned WORD_W   = 32,
    parameter bit          ZAP_MODE = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              stall_req,
    input logic [WORD_W-1:0] fetch_pc,
    input logic [WORD_W-1:0] ifid_instr,
    input logic              ifid_valid,
    input logic              branch_taken,
    input logic              slot_error,
    input logic [WORD_W-1:0] target
);
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        stall_req |=> $stable(fetch_pc) && $stable(ifid_instr) && $stable(ifid_valid));

    p_nop_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !ifid_valid |-> ifid_instr == '0);

    p_redirect_r4: assert property (@(posedge clk) disable iff (rst)
        (branch_taken && !stall_req) |=> fetch_pc == $past(target));

    p_no_slot_redirect_r10: assert property (@(posedge clk) disable iff (rst)
        slot_error |-> !branch_taken);

    p_stall_no_take_r8: assert property (@(posedge clk) disable iff (rst)
        stall_req |-> !branch_taken);

    generate
        if (ZAP_MODE) begin : g_zap
            p_zap_bubble_r11: assert property (@(posedge clk) disable iff (rst)
                (branch_taken && !stall_req) |=> !ifid_valid);
        end else begin : g_slot
            p_slot_kept_r4: assert property (@(posedge clk) disable iff (rst)
                (branch_taken && !stall_req) |=> ifid_valid);
            p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
                (!branch_taken && !stall_req) |=> fetch_pc == $past(fetch_pc) + WORD_W'(4));
        end
    endgenerate
endmodule

bind delay_fetch_seq dfs_checker #(.WORD_W(WORD_W), .ZAP_MODE(ZAP_MODE)) u_dfs_checker (
    .clk          (clk),
    .rst          (rst),
    .stall_req    (stall_req),
    .fetch_pc     (fetch_pc),
    .ifid_instr   (ifid_instr),
    .ifid_valid   (ifid_valid),
    .branch_taken (branch_taken),
    .slot_error   (slot_error),
    .target       (tgt)
);

// File: tb/delay_fetch_seq_bench.sv
module delay_fetch_seq_bench;
    localparam logic [31:0] P0 = 32'h0040_0000;

    typedef struct packed {
        logic        sel;
        logic [31:0] pc;
        logic [31:0] instr;
        logic        valid;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0]  kind = 3'd0;
    logic        likely = 1'b0;
    logic [31:0] rs = '0, rt = '0, off = '0;
    logic [25:0] jidx = '0;
    logic        stall = 1'b0;

    logic [31:0] pc_a, in_a, pc_b, in_b;
    logic        v_a, tk_a, er_a, v_b, tk_b, er_b;

    exp_t  expq[$];
    string tagq[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [31:0] iw(input logic [31:0] a);
        return {8'hC3, a[23:0]};
    endfunction

    delay_fetch_seq #(.RESET_VEC(P0), .ZAP_MODE(1'b0)) u_delay_fetch_seq (
        .clk(clk), .rst(rst), .fetch_instr(iw(pc_a)), .dec_kind(kind),
        .dec_likely(likely), .rs_val(rs), .rt_val(rt), .off_ext(off),
        .jump_idx(jidx), .stall_req(stall), .fetch_pc(pc_a),
        .ifid_instr(in_a), .ifid_valid(v_a), .branch_taken(tk_a), .slot_error(er_a));

    delay_fetch_seq #(.RESET_VEC(P0), .ZAP_MODE(1'b1)) u_delay_fetch_seq_zap (
        .clk(clk), .rst(rst), .fetch_instr(iw(pc_b)), .dec_kind(kind),
        .dec_likely(likely), .rs_val(rs), .rt_val(rt), .off_ext(off),
        .jump_idx(jidx), .stall_req(stall), .fetch_pc(pc_b),
        .ifid_instr(in_b), .ifid_valid(v_b), .branch_taken(tk_b), .slot_error(er_b));

    task automatic cmp_regs(input exp_t e, input string tag);
        logic [31:0] p, w;
        logic        v;
        p = e.sel ? pc_b : pc_a;
        w = e.sel ? in_b : in_a;
        v = e.sel ? v_b  : v_a;
        n_chk++;
        if (p !== e.pc || w !== e.instr || v !== e.valid) begin
            n_bad++;
            $display("FAIL %s: pc %h instr %h valid %b, expected pc %h instr %h valid %b",
                     tag, p, w, v, e.pc, e.instr, e.valid);
        end
    endtask

    // monitor: pops one expectation per edge
    always @(posedge clk) begin
        #1;
        if (expq.size() > 0) cmp_regs(expq.pop_front(), tagq.pop_front());
    end

    // driver: called at posedge+2, leaves at next posedge+2
    task automatic step(input bit sel, input logic [2:0] k, input bit lk,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] o, input logic [25:0] j, input bit st,
                        input bit e_tk, input bit e_er,
                        input logic [31:0] e_pc, input logic [31:0] e_in,
                        input bit e_v, input string tag);
        kind = k; likely = lk; rs = a; rt = b; off = o; jidx = j; stall = st;
        #1;
        n_chk++;
        if ((sel ? tk_b : tk_a) !== e_tk || (sel ? er_b : er_a) !== e_er) begin
            n_bad++;
            $display("FAIL %s: taken %b error %b, expected taken %b error %b",
                     tag, sel ? tk_b : tk_a, sel ? er_b : er_a, e_tk, e_er);
        end
        expq.push_back('{sel: sel, pc: e_pc, instr: e_in, valid: e_v});
        tagq.push_back(tag);
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input bit sel);
        rst = 1'b1; kind = 3'd0; likely = 1'b0; stall = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #2;
        rst = 1'b0;
        cmp_regs('{sel: sel, pc: P0, instr: 32'h0, valid: 1'b0}, "R1 reset");
    endtask

    initial begin
        do_reset(1'b0);
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, P0+32'h04, iw(P0), 1, "R2 seq a");
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, P0+32'h08, iw(P0+32'h04), 1, "R2 seq b");
        step(0, 3'd1, 0, 5, 5, 32'd16, 0, 0, 1, 0, P0+32'h48, iw(P0+32'h08), 1, "R4 taken eq");
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, P0+32'h4C, iw(P0+32'h48), 1, "R2 after slot");
        step(0, 3'd2, 0, 3, 3, 32'd16, 0, 0, 0, 0, P0+32'h50, iw(P0+32'h4C), 1, "R6 ne not taken");
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, P0+32'h54, iw(P0+32'h50), 1, "R6 slot run");
        step(0, 3'd5, 1, 32'hFFFF_FFFF, 0, 32'hFFFF_FFF8, 0, 0, 1, 0, P0+32'h34, iw(P0+32'h54), 1, "R7 likely taken");
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, P0+32'h38, iw(P0+32'h34), 1, "R4 backward");
        step(0, 3'd6, 1, 32'hFFFF_FFFB, 0, 32'd16, 0, 0, 0, 0, P0+32'h3C, 32'h0, 0, "R7 likely annul");
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, P0+32'h40, iw(P0+32'h3C), 1, "R7 after bubble");
        step(0, 3'd4, 0, 1, 0, 32'd4, 0, 1, 0, 0, P0+32'h40, iw(P0+32'h3C), 1, "R8 stalled branch");
        step(0, 3'd4, 0, 1, 0, 32'd4, 0, 0, 1, 0, P0+32'h50, iw(P0+32'h40), 1, "R8 deferred redirect");
        step(0, 3'd0, 0, 0, 0, 0, 0, 1, 0, 0, P0+32'h50, iw(P0+32'h40), 1, "R9 slot stall a");
        step(0, 3'd0, 0, 0, 0, 0, 0, 1, 0, 0, P0+32'h50, iw(P0+32'h40), 1, "R9 slot stall b");
        step(0, 3'd1, 0, 7, 7, 32'd16, 0, 0, 0, 1, P0+32'h54, iw(P0+32'h50), 1, "R10 branch in slot");
        step(0, 3'd7, 0, 0, 0, 0, 26'h010_0040, 0, 1, 0, 32'h0040_0100, iw(P0+32'h54), 1, "R5 jump");
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0040_0104, iw(32'h0040_0100), 1, "R5 jump slot");
        step(0, 3'd3, 0, 0, 0, 32'd2, 0, 0, 1, 0, 32'h0040_010C, iw(32'h0040_0104), 1, "R3 lez at zero");
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0040_0110, iw(32'h0040_010C), 1, "R3 slot");
        step(0, 3'd4, 0, 32'h8000_0000, 0, 32'd2, 0, 0, 0, 0, 32'h0040_0114, iw(32'h0040_0110), 1, "R3 gtz signed");
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0040_0118, iw(32'h0040_0114), 1, "R3 slot b");
        step(0, 3'd5, 1, 0, 0, 32'd2, 0, 0, 0, 0, 32'h0040_011C, 32'h0, 0, "R7 ltz at zero annul");

        do_reset(1'b1);
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, P0+32'h04, iw(P0), 1, "R2 zap seq");
        step(1, 3'd1, 0, 4, 4, 32'd4, 0, 0, 1, 0, P0+32'h14, 32'h0, 0, "R11 zap taken");
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, P0+32'h18, iw(P0+32'h14), 1, "R11 zap target");
        step(1, 3'd2, 0, 4, 4, 32'd4, 0, 0, 0, 0, P0+32'h18, 32'h0, 0, "R11 zap not taken");
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, P0+32'h1C, iw(P0+32'h18), 1, "R11 zap refetch");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule